// File: doc/BRIEF.md
# Framed Serial Sample Output Port

This block sends 16-bit converter results over a synchronous serial link timed entirely by a master clock. Samples arrive on a parallel bus with a load strobe. A rising edge on the frame-sync input sets the word timing. From then on the port repeats a fixed word period without further prompting. It produces its own serial clock, serial data sent most significant bit first, and a frame-sync output.

Configuration pins choose the following:
- the word period: 32 or 16 master cycles;
- the serial clock rate: equal to the master clock, or half of it;
- which serial clock transition is the one on which data changes;
- the frame-sync output shape: a one-bit end-of-word pulse, or a level held across the word.

The data output has a separate drive enable, so two ports can share one data line. In the 32-cycle mode with the serial clock at full rate, a word fills only the first 16 cycles. The frame-sync pulse of one port, fed to the frame-sync input of a second port, places the second port's word in the remaining 16 cycles.

Top module: `fsp_serial_port`

## Requirements
- R1: Each word is 16 bits sent most significant bit first. Bit 15 of the word is on `sdata_o` during the first bit period after the clock edge that starts the frame.
- R2: The word period is 32 master cycles when `cfg_dec_short_i`=0 and 16 when it is 1. Words follow one another without a new frame-sync.
- R3: A bit lasts two master cycles only when `cfg_dec_short_i`=0 and `cfg_sclk_fast_i`=0. In that case the serial clock runs at half rate: it is high in the first cycle of each bit when `cfg_sclk_inv_i`=0. Otherwise a bit lasts one master cycle and the serial clock follows the master clock. In the 16-cycle mode `cfg_sclk_fast_i` has no effect.
- R4: A clock edge at which `fs_in_i` is 1, after being 0 at the previous edge, makes the next cycle cycle 0 of a word. A rising edge in the middle of a word restarts the frame.
- R5: With `cfg_fs_level_i`=0, `fs_out_o` is high for the last bit period of each word (bit 0). With `cfg_fs_level_i`=1, it is high for all 16 bit periods.
- R6: After a frame start, `fs_out_o` stays low for as long as `fs_in_i` stays high.
- R7: A sample captured by `sample_load_i` enters the word only at a word boundary (a frame start or a period wrap). The word being sent does not change.
- R8: `sdata_oe_o` is 1 only when `drive_en_i`=1 and one of the 16 bit periods is in progress. Outside the bit periods, `sdata_o` is 0.
- R9: `drive_en_i`=0 releases the data line but does not stop the word counter, so the next word stays aligned to the frame.
- R10: `cfg_sclk_inv_i`=1 inverts the serial clock, so data changes on its falling transition instead of its rising one.
- R11: After reset: no frame is running, `sdata_oe_o`=0, `fs_out_o`=0 and `sdata_o`=0. The serial clock is high in half-rate mode with `cfg_sclk_inv_i`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_i | input | 16 | Parallel sample |
| sample_load_i | input | 1 | Captures `sample_i` for the next word |
| fs_in_i | input | 1 | Frame-sync input; a rising edge starts a frame |
| drive_en_i | input | 1 | Lets the port drive the data line |
| cfg_dec_short_i | input | 1 | 1: 16-cycle word period, 0: 32-cycle |
| cfg_sclk_fast_i | input | 1 | 1: serial clock at master rate, 0: half rate |
| cfg_sclk_inv_i | input | 1 | Inverts the serial clock |
| cfg_fs_level_i | input | 1 | 1: frame-sync level over the word, 0: end pulse |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Drive enable for the serial data line |
| fs_out_o | output | 1 | Frame-sync output |

## Verification
A wrong word counter moves every output of the port at once. Serial data shows the wrong bit within one cycle of the fault. The frame-sync output appears at the wrong place within one word. The half-rate serial clock shows the wrong phase in the very next cycle. A word register loaded at the wrong time shows up as wrong data bits during the same word. A wrong load or release state only shows when the next word starts or the frame-sync drops, so the bench runs two consecutive words for every configuration and holds the frame-sync input high in some of the runs.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef struct packed {
        logic dec_short;
        logic sclk_fast;
        logic sclk_inv;
        logic fs_level;
    } fsp_cfg_t;

    // Two master cycles per bit only in the long period with a slow serial clock.
    function automatic logic fsp_half_rate(fsp_cfg_t c);
        return !c.sclk_fast && !c.dec_short;
    endfunction

endpackage

// File: rtl/fsp_frame_timer.sv
module fsp_frame_timer #(
    parameter int WORD_BITS = 16,
    localparam int LONG_CYC = 2 * WORD_BITS,
    localparam int CNT_W = $clog2(LONG_CYC)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             dec_short_i,
    input  logic             fs_in_i,
    output logic [CNT_W-1:0] cyc_o,
    output logic             running_o,
    output logic             released_o,
    output logic             boundary_o
);
    logic [CNT_W-1:0] cyc_q;
    logic             running_q;
    logic             released_q;
    logic             fs_prev_q;
    logic [CNT_W-1:0] last_cyc;
    logic             start;

    assign last_cyc   = dec_short_i ? CNT_W'(WORD_BITS - 1) : CNT_W'(LONG_CYC - 1);
    assign start      = fs_in_i && !fs_prev_q;
    assign boundary_o = start || (running_q && (cyc_q >= last_cyc));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cyc_q      <= '0;
            running_q  <= 1'b0;
            released_q <= 1'b0;
            fs_prev_q  <= 1'b0;
        end else begin
            fs_prev_q <= fs_in_i;
            if (start) begin
                cyc_q      <= '0;
                running_q  <= 1'b1;
                released_q <= 1'b0;
            end else begin
                if (running_q)
                    cyc_q <= (cyc_q >= last_cyc) ? '0 : cyc_q + 1'b1;
                if (!fs_in_i)
                    released_q <= 1'b1;
            end
        end
    end

    assign cyc_o      = cyc_q;
    assign running_o  = running_q;
    assign released_o = released_q;

    AST_START_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
        start |=> (running_q && cyc_q == '0)); // R4
    AST_COUNT_STEPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (running_q && !start && cyc_q < last_cyc) |=> (cyc_q == $past(cyc_q) + 1'b1)); // R2
    AST_RELEASE_AFTER_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(released_q) |-> !$past(fs_in_i)); // R6

endmodule

// File: rtl/fsp_word_store.sv
module fsp_word_store #(
    parameter int WORD_BITS = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [WORD_BITS-1:0] sample_i,
    input  logic                 load_i,
    input  logic                 boundary_i,
    output logic [WORD_BITS-1:0] word_o
);
    logic [WORD_BITS-1:0] hold_q;
    logic [WORD_BITS-1:0] word_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_q <= '0;
            word_q <= '0;
        end else begin
            if (load_i)
                hold_q <= sample_i;
            if (boundary_i)
                word_q <= hold_q;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/fsp_serializer.sv
module fsp_serializer
    import fsp_pkg::*;
#(
    parameter int WORD_BITS = 16,
    localparam int CNT_W = $clog2(2 * WORD_BITS),
    localparam int BIT_W = $clog2(WORD_BITS)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  fsp_cfg_t             cfg_i,
    input  logic [CNT_W-1:0]     cyc_i,
    input  logic                 running_i,
    input  logic [WORD_BITS-1:0] word_i,
    input  logic                 released_i,
    input  logic                 fs_in_i,
    input  logic                 drive_en_i,
    output logic                 sclk_o,
    output logic                 sdata_o,
    output logic                 oe_o,
    output logic                 fs_out_o
);
    logic             half;
    logic             active;
    logic [CNT_W-1:0] bit_idx;
    logic [BIT_W-1:0] bit_pos;
    logic             last_bit;
    logic             fs_gate;

    assign half     = fsp_half_rate(cfg_i);
    assign bit_idx  = half ? (cyc_i >> 1) : cyc_i;
    assign active   = running_i && (half || (cyc_i < CNT_W'(WORD_BITS)));
    assign bit_pos  = BIT_W'(WORD_BITS - 1) - bit_idx[BIT_W-1:0];
    assign last_bit = (bit_idx[BIT_W-1:0] == '1);
    assign fs_gate  = released_i || !fs_in_i;

    assign sclk_o   = half ? (!cyc_i[0] ^ cfg_i.sclk_inv) : (clk_i ^ cfg_i.sclk_inv);
    assign sdata_o  = active && word_i[bit_pos];
    assign oe_o     = active && drive_en_i;
    assign fs_out_o = active && fs_gate && (cfg_i.fs_level || last_bit);

    AST_OE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        oe_o |-> drive_en_i); // R8
    AST_NO_DATA_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !running_i |-> (!sdata_o && !oe_o && !fs_out_o)); // R11

endmodule

// File: rtl/fsp_serial_port.sv
module fsp_serial_port
    import fsp_pkg::*;
#(
    parameter int WORD_BITS = 16,
    localparam int CNT_W = $clog2(2 * WORD_BITS)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [WORD_BITS-1:0] sample_i,
    input  logic                 sample_load_i,
    input  logic                 fs_in_i,
    input  logic                 drive_en_i,
    input  logic                 cfg_dec_short_i,
    input  logic                 cfg_sclk_fast_i,
    input  logic                 cfg_sclk_inv_i,
    input  logic                 cfg_fs_level_i,
    output logic                 sclk_o,
    output logic                 sdata_o,
    output logic                 sdata_oe_o,
    output logic                 fs_out_o
);
    fsp_cfg_t             cfg;
    logic [CNT_W-1:0]     cyc;
    logic                 running;
    logic                 released;
    logic                 boundary;
    logic [WORD_BITS-1:0] word;

    assign cfg = '{dec_short: cfg_dec_short_i, sclk_fast: cfg_sclk_fast_i,
                   sclk_inv: cfg_sclk_inv_i, fs_level: cfg_fs_level_i};

    fsp_frame_timer #(.WORD_BITS(WORD_BITS)) i_timer (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .dec_short_i (cfg_dec_short_i),
        .fs_in_i     (fs_in_i),
        .cyc_o       (cyc),
        .running_o   (running),
        .released_o  (released),
        .boundary_o  (boundary)
    );

    fsp_word_store #(.WORD_BITS(WORD_BITS)) i_store (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sample_i   (sample_i),
        .load_i     (sample_load_i),
        .boundary_i (boundary),
        .word_o     (word)
    );

    fsp_serializer #(.WORD_BITS(WORD_BITS)) i_ser (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cfg_i      (cfg),
        .cyc_i      (cyc),
        .running_i  (running),
        .word_i     (word),
        .released_i (released),
        .fs_in_i    (fs_in_i),
        .drive_en_i (drive_en_i),
        .sclk_o     (sclk_o),
        .sdata_o    (sdata_o),
        .oe_o       (sdata_oe_o),
        .fs_out_o   (fs_out_o)
    );

    AST_WORD_HELD_MIDWORD: assert property (@(posedge clk_i) disable iff (rst_i)
        (running && !boundary) |=> $stable(word)); // R7
    AST_FS_HELD_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (fs_in_i && !released) |-> !fs_out_o); // R6

endmodule

// File: tb/test_fsp_serial_port.sv
`timescale 1ns/1ps
module test_fsp_serial_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] sample = '0;
    logic        load = 1'b0;
    logic        fs_in = 1'b0;
    logic        en = 1'b1;
    logic        dec_short = 1'b0;
    logic        fast = 1'b0;
    logic        inv = 1'b0;
    logic        lvl = 1'b0;
    logic        sclk, sdata, oe, fs_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fsp_serial_port i_fsp_serial_port (
        .clk_i           (clk),
        .rst_i           (rst),
        .sample_i        (sample),
        .sample_load_i   (load),
        .fs_in_i         (fs_in),
        .drive_en_i      (en),
        .cfg_dec_short_i (dec_short),
        .cfg_sclk_fast_i (fast),
        .cfg_sclk_inv_i  (inv),
        .cfg_fs_level_i  (lvl),
        .sclk_o          (sclk),
        .sdata_o         (sdata),
        .sdata_oe_o      (oe),
        .fs_out_o        (fs_out)
    );

    task automatic chk(input logic got, input logic exp, input string tag, input int k);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cfg=%b%b%b%b k=%0d: actual=%b expected=%b",
                     tag, dec_short, fast, inv, lvl, k, got, exp);
        end
    endtask

    // One frame start followed by two full words; expected values from the requirements.
    task automatic run_frame(input logic [15:0] a, input logic [15:0] b,
                             input bit en_late, input bit hold_fs);
        int p, bp, c, w, bi;
        logic [15:0] wd;
        logic act, e_data, e_oe, e_fs, e_sclk, gate, e_en;
        @(posedge clk); #1;
        sample = a; load = 1'b1;
        @(posedge clk); #1;
        load = 1'b0; fs_in = 1'b1;
        p  = dec_short ? 16 : 32;
        bp = (!fast && !dec_short) ? 2 : 1;
        for (int k = 0; k < 2 * p; k++) begin
            @(posedge clk); #1;
            if (!hold_fs) fs_in = 1'b0;
            if (k == 3) begin sample = b; load = 1'b1; end else load = 1'b0;
            en = en_late ? (k >= p) : 1'b1;
            #2;
            c  = k % p;
            w  = k / p;
            wd = (w == 0) ? a : b;
            act = (c < 16 * bp);
            bi = c / bp;
            e_data = act ? wd[15 - bi] : 1'b0;
            e_en = en_late ? (k >= p) : 1'b1;
            e_oe = act && e_en;
            gate = !hold_fs;
            e_fs = act && gate && (lvl || bi == 15);
            e_sclk = (bp == 2) ? ((c % 2 == 0) ? !inv : inv) : inv;
            chk(sdata, e_data, (w == 0) ? "R1 data msb-first" : "R7 next-word data", k);
            chk(oe, e_oe, en_late ? "R9 drive release alignment" : "R8 drive enable", k);
            chk(fs_out, e_fs, hold_fs ? "R6 fs suppressed" : "R5 fs shape", k);
            chk(sclk, e_sclk, (bp == 2) ? "R3 half-rate sclk" : "R10 sclk polarity", k);
        end
        fs_in = 1'b0; en = 1'b1; load = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        chk(oe, 1'b0, "R11 reset oe", 0);
        chk(fs_out, 1'b0, "R11 reset fs", 0);
        chk(sdata, 1'b0, "R11 reset data", 0);
        chk(sclk, 1'b1, "R11 reset sclk", 0);
        // Sweep every configuration; each second run restarts mid-word (R4) and
        // checks R2 through the second word's position.
        for (int m = 0; m < 16; m++) begin
            @(posedge clk); #1;
            dec_short = m[0]; fast = m[1]; inv = m[2]; lvl = m[3];
            run_frame(16'hA5C3 ^ 16'(m * 16'h1111), 16'h3C96 + 16'(m), 1'b0, 1'b0);
            run_frame(16'h8001 + 16'(m << 4), 16'h7FFE - 16'(m), 1'b1, m[0]);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule